// File: doc/BRIEF.md
# Shared-Network Barrel Shifter with Carry Rotates

This block shifts or rotates a 32-bit word by any amount from 0 to 31 and registers the result on the next rising clock edge. Six operations are available: logical shifts left and right, plain rotates left and right, and rotates left and right through a carry flag. The carry rotates treat the carry flag and the data word as one 33-bit ring.

All six operations use a single logarithmic right-funnel network. Left operations become right rotations by the complementary amount. Vacated bit positions of the logical shifts are cleared with a mask built from the amount. The block sits in the execute stage of a datapath. The operation code, operand, amount and carry flag arrive each cycle, and the result and carry flag are read one cycle later.

Top module: `barrel_shift_unit`

## Requirements
- R1: Operation code 0 (shift left): the result is the data shifted left by the amount, with zeros entering at bit 0. For a nonzero amount n, carry_o is data bit 32-n.
- R2: Operation code 1 (shift right): the result is the data shifted right by the amount, with zeros entering at bit 31. For a nonzero amount n, carry_o is data bit n-1.
- R3: Operation code 2 (rotate right): the result is the data rotated right by the amount, and carry_o equals carry_i.
- R4: Operation code 3 (rotate left): the result is the data rotated left by the amount, and carry_o equals carry_i.
- R5: Operation code 4 (rotate left through carry): the 33-bit value {carry_i, data} (carry in bit 32) is rotated left by the amount. The result is its bits 31:0 and carry_o is its bit 32.
- R6: Operation code 5 (rotate right through carry): the same 33-bit value is rotated right by the amount. The result is bits 31:0 and carry_o is bit 32.
- R7: With an amount of 0, codes 0 and 1 return the data unchanged and pass carry_i to carry_o.
- R8: Operation codes 6 and 7 return the data unchanged and pass carry_i to carry_o, whatever the amount.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge. During a rising edge with rst_n low, both outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code |
| data_i | input | 32 | Operand word |
| amt_i | input | 5 | Shift or rotate amount |
| carry_i | input | 1 | Carry flag in |
| result_o | output | 32 | Registered result word |
| carry_o | output | 1 | Registered carry flag out |

## Verification
Every operation code is swept over all 32 amounts with four fixed operands:
- A pattern with only the end bits set shows the wrap-around and the carry-out position.
- An irregular pattern catches a wrong rotate amount or a wrong direction.
- All ones exposes a missing clear of vacated bits.
- Zero with the carry set shows whether the carry actually travels through the 33-bit ring in the carry rotates.

Random operands, amounts, carries and codes from a fixed seed then cover mixtures that the sweeps do not reach. Reset is checked before use and again when asserted in the middle of traffic.

// File: rtl/bsu_pkg.sv
// Package: bsu_pkg
// Shared operation encoding for the barrel shift unit.
// Assumes a 3-bit operation field; codes 6 and 7 mean pass-through.
package bsu_pkg;

    typedef enum logic [2:0] {
        OP_SHL   = 3'd0,
        OP_SHR   = 3'd1,
        OP_ROR   = 3'd2,
        OP_ROL   = 3'd3,
        OP_ROLC  = 3'd4,
        OP_RORC  = 3'd5,
        OP_PASSA = 3'd6,
        OP_PASSB = 3'd7
    } bsu_op_e;

endpackage

// File: rtl/bsu_decode.sv
// Module: bsu_decode
// Turns an operation, operand, amount and carry into the funnel input
// vector and the right-rotate amount of the shared network.
// Assumes: the network rotates a doubled copy of the ring right by ramt_o,
// so left operations use (ring width - n) and amount 0 maps to 0.
module bsu_decode
    import bsu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W),
    parameter int AW = $clog2(W + 2)
) (
    input  bsu_op_e          op_i,
    input  logic [W-1:0]     data_i,
    input  logic [SW-1:0]    amt_i,
    input  logic             carry_i,
    output logic [2*W+1:0]   vec_o,
    output logic [AW-1:0]    ramt_o
);

    localparam logic [AW-1:0] WIDE32 = AW'(W);
    localparam logic [AW-1:0] WIDE33 = AW'(W + 1);

    logic [W:0]    ring33;
    logic [AW-1:0] amt_w;
    logic          amt_zero;

    assign ring33   = {carry_i, data_i};
    assign amt_w    = AW'(amt_i);
    assign amt_zero = (amt_i == '0);

    // Pick the ring contents and the equivalent right-rotate amount.
    always_comb begin
        vec_o  = {2'b00, data_i, data_i};
        ramt_o = '0;
        unique case (op_i)
            OP_SHL, OP_ROL: ramt_o = amt_zero ? '0 : (WIDE32 - amt_w);
            OP_SHR, OP_ROR: ramt_o = amt_w;
            OP_ROLC: begin
                vec_o  = {ring33, ring33};
                ramt_o = amt_zero ? '0 : (WIDE33 - amt_w);
            end
            OP_RORC: begin
                vec_o  = {ring33, ring33};
                ramt_o = amt_w;
            end
            default: ramt_o = '0;
        endcase
    end

endmodule

// File: rtl/bsu_funnel.sv
// Module: bsu_funnel
// Logarithmic right funnel: output bit j is input bit j + amt_i.
// Stage b moves by 2**b; each stage narrows so every input bit is used.
// Assumes 2**AW >= W + 2 so the doubled 33-bit ring fits the first stage.
module bsu_funnel #(
    parameter int W  = 32,
    parameter int AW = $clog2(W + 2),
    parameter int IN = 2 * W + 2
) (
    input  logic [IN-1:0] vec_i,
    input  logic [AW-1:0] amt_i,
    output logic [W:0]    rot_o
);

    localparam int TOPW = W + (1 << AW);

    for (genvar b = AW - 1; b >= 0; b--) begin : g_stg
        localparam int SH = 1 << b;
        localparam int OW = W + SH;
        localparam int IW = OW + SH;

        logic [IW-1:0] si;
        logic [OW-1:0] so;

        if (b == AW - 1) begin : g_first
            assign si = {{(TOPW - IN){1'b0}}, vec_i};
        end else begin : g_next
            assign si = g_stg[b+1].so;
        end

        // Move by 2**b when this amount bit is set.
        always_comb so = amt_i[b] ? si[IW-1:SH] : si[OW-1:0];
    end

    assign rot_o = g_stg[0].so;

endmodule

// File: rtl/bsu_mask.sv
// Module: bsu_mask
// Builds the keep-mask for logical shifts from the amount.
// Left shifts keep bits at or above n; right shifts keep bits below W-n.
// Assumes at most one of left_i / right_i is set; neither gives all ones.
module bsu_mask #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          right_i,
    output logic [W-1:0]  mask_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic keep_l;
        logic keep_r;
        assign keep_l = (amt_i <= SW'(i));
        assign keep_r = (amt_i <= SW'(W - 1 - i));
        // Select the keep rule for this bit.
        always_comb begin
            if (left_i)       mask_o[i] = keep_l;
            else if (right_i) mask_o[i] = keep_r;
            else              mask_o[i] = 1'b1;
        end
    end

endmodule

// File: rtl/barrel_shift_unit.sv
// Module: barrel_shift_unit
// Single-cycle 32-bit barrel shifter: six shift/rotate operations on one
// shared right-funnel network, outputs registered once.
// Assumes synchronous active-low reset; codes 6/7 pass data through.
module barrel_shift_unit
    import bsu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W),
    parameter int AW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          carry_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o
);

    bsu_op_e        op;
    logic [2*W+1:0] vec;
    logic [AW-1:0]  ramt;
    logic [W:0]     rot;
    logic [W-1:0]   mask;
    logic [W-1:0]   result_d;
    logic           carry_d;
    logic           amt_zero;

    assign op       = bsu_op_e'(op_i);
    assign amt_zero = (amt_i == '0);

    bsu_decode #(.W(W), .SW(SW), .AW(AW)) i_decode (
        .op_i    (op),
        .data_i  (data_i),
        .amt_i   (amt_i),
        .carry_i (carry_i),
        .vec_o   (vec),
        .ramt_o  (ramt)
    );

    bsu_funnel #(.W(W), .AW(AW), .IN(2 * W + 2)) i_funnel (
        .vec_i (vec),
        .amt_i (ramt),
        .rot_o (rot)
    );

    bsu_mask #(.W(W), .SW(SW)) i_mask (
        .amt_i   (amt_i),
        .left_i  (op == OP_SHL),
        .right_i (op == OP_SHR),
        .mask_o  (mask)
    );

    // Clear vacated bits; take the carry from where the last bit landed.
    always_comb begin
        result_d = rot[W-1:0] & mask;
        unique case (op)
            OP_SHL:           carry_d = amt_zero ? carry_i : rot[0];
            OP_SHR:           carry_d = amt_zero ? carry_i : rot[W-1];
            OP_ROLC, OP_RORC: carry_d = rot[W];
            default:          carry_d = carry_i;
        endcase
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else begin
            result_o <= result_d;
            carry_o  <= carry_d;
        end
    end

endmodule

// File: rtl/barrel_shift_unit_chk.sv
// Module: barrel_shift_unit_chk
// Property checker for barrel_shift_unit, bound below. Keeps its own copy
// of last cycle's inputs and compares the registered outputs with
// arithmetic-shift formulations of each operation.
module barrel_shift_unit_chk #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          carry_i,
    input  logic [W-1:0]  result_o,
    input  logic          carry_o
);

    logic [2:0]    p_op;
    logic [W-1:0]  p_d;
    logic [SW-1:0] p_n;
    logic          p_c;
    logic          p_ok;
    logic          p_rst;

    // Capture the inputs the output register saw.
    always_ff @(posedge clk) begin
        p_op  <= op_i;
        p_d   <= data_i;
        p_n   <= amt_i;
        p_c   <= carry_i;
        p_rst <= !rst_n;
        if (!rst_n) p_ok <= 1'b0;
        else        p_ok <= 1'b1;
    end

    logic [W:0]       shl_x;
    logic [W:0]       shr_x;
    logic [2*W-1:0]   dd;
    logic [2*W+1:0]   rr;
    logic [2*W+1:0]   rl;
    logic [W-1:0]     ror_v;
    logic [W-1:0]     rol_v;

    assign shl_x = {1'b0, p_d} << p_n;
    assign shr_x = {p_d, 1'b0} >> p_n;
    assign dd    = {p_d, p_d};
    assign ror_v = W'(dd >> p_n);
    assign rol_v = W'((dd << p_n) >> W);
    assign rr    = {p_c, p_d, p_c, p_d} >> p_n;
    assign rl    = {p_c, p_d, p_c, p_d} << p_n;

    assert_shl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == 3'd0 && p_n != '0) |-> (result_o == shl_x[W-1:0] && carry_o == shl_x[W]));

    assert_shr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == 3'd1 && p_n != '0) |-> (result_o == shr_x[W:1] && carry_o == shr_x[0]));

    assert_ror_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == 3'd2) |-> (result_o == ror_v && carry_o == p_c));

    assert_rol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == 3'd3) |-> (result_o == rol_v && carry_o == p_c));

    assert_rolc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == 3'd4) |-> ({carry_o, result_o} == rl[2*W+1:W+1]));

    assert_rorc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == 3'd5) |-> ({carry_o, result_o} == rr[W:0]));

    assert_zero_amt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op <= 3'd1 && p_n == '0) |-> (result_o == p_d && carry_o == p_c));

    assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op >= 3'd6) |-> (result_o == p_d && carry_o == p_c));

    assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        p_rst |-> (result_o == '0 && carry_o == 1'b0));

endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(.W(W), .SW(SW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .data_i   (data_i),
    .amt_i    (amt_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/test_barrel_shift_unit.sv
// Bench for barrel_shift_unit: directed sweeps of every code over every
// amount, then seeded random traffic, against a bit-serial model.
module test_barrel_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_i;
    logic [31:0] data_i;
    logic [4:0]  amt_i;
    logic        carry_i;
    logic [31:0] result_o;
    logic        carry_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    barrel_shift_unit i_barrel_shift_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .data_i   (data_i),
        .amt_i    (amt_i),
        .carry_i  (carry_i),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

    // One-bit-at-a-time model; returns {carry, result}.
    function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] d,
                                          input logic [4:0] n, input logic c);
        logic [31:0] v = d;
        logic        k = c;
        for (int s = 0; s < int'(n); s++) begin
            case (op)
                3'd0: begin k = v[31]; v = {v[30:0], 1'b0}; end
                3'd1: begin k = v[0];  v = {1'b0, v[31:1]}; end
                3'd2: v = {v[0], v[31:1]};
                3'd3: v = {v[30:0], v[31]};
                3'd4: begin logic t = v[31]; v = {v[30:0], k}; k = t; end
                3'd5: begin logic t = v[0];  v = {k, v[31:1]}; k = t; end
                default: ;
            endcase
        end
        return {k, v};
    endfunction

    function automatic string tag(input logic [2:0] op, input logic [4:0] n);
        if (op <= 3'd1 && n == 5'd0) return "R7";
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got carry=%0b result=%08h expected carry=%0b result=%08h",
                     req, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic apply(input logic [2:0] op, input logic [31:0] d,
                         input logic [4:0] n, input logic c);
        op_i = op; data_i = d; amt_i = n; carry_i = c;
        @(negedge clk);
        check(tag(op, n), {carry_o, result_o}, model(op, d, n, c));
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'hA5C3_0F96;
        pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h0000_0000;
        void'($urandom(32'd1234));
        rst_n = 1'b0; op_i = 3'd0; data_i = 32'hDEAD_BEEF; amt_i = 5'd7; carry_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", {carry_o, result_o}, 33'd0);
        rst_n = 1'b1;
        for (int op = 0; op < 8; op++)
            for (int n = 0; n < 32; n++)
                for (int p = 0; p < 4; p++)
                    apply(3'(op), pats[p], 5'(n), (p == 3) || (n[0] ^ p[0]));
        for (int i = 0; i < 1500; i++)
            apply(3'($urandom_range(0, 7)), $urandom, 5'($urandom_range(0, 31)), 1'($urandom));
        // Reset in the middle of traffic clears both outputs (R9).
        op_i = 3'd5; data_i = 32'h1234_5678; amt_i = 5'd3; carry_i = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R9", {carry_o, result_o}, 33'd0);
        rst_n = 1'b1;
        apply(3'd5, 32'h1234_5678, 5'd3, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule